// File: doc/BRIEF.md
# Timer-Triggered Pulse Output Port

This block drives two 4-bit pin groups. Each group is either an ordinary parallel port or a timed pulse output. A parallel port shows its data register on the pins as soon as the register is written. A pulse output copies the low nibble of its data register to the pins only when the group's own down-counting timer underflows. Software can therefore load the next pattern at any time, and the pins change on an exact timer boundary.

Group 0 can be inverted. Group 1 can be gated by an external modulation signal that comes from a third timer. A select field and two per-group enable bits decide which groups run as pulse outputs. The mode register is locked against writes until an unlock bit is set. Each timer divides the base clock by a selectable prescaler and reloads from its own reload register.

All configuration goes through a write-only register bus. The addresses are:

| Address | Contents |
|---|---|
| 0 | Unlock bit |
| 1 | Mode register |
| 2 | Group 0 data |
| 3 | Group 1 data |
| 4 | Group 0 clock select |
| 5 | Group 1 clock select |
| 6 | Group 0 reload |
| 7 | Group 1 reload |

Top module: `rtpo_top`

## Requirements
- R1: After reset all registers are zero, both pin groups drive 0 and both groups are parallel ports.
- R2: A group that is not an active pulse output drives its data register nibble (low 4 bits of the write to address 2 or 3) on its pins from the clock edge that accepts the write.
- R3: The mode select field is bits [2:0] of the mode register.
  - 001 makes only group 1 a pulse output.
  - 010 makes only group 0 a pulse output.
  - 011 makes both groups pulse outputs.
  - 000 and every 1xx value leave both groups as parallel ports.
- R4: While a group is an active pulse output, its pins change only on its timer's underflow edge. On that edge the pins take the current data nibble. A data write between underflows leaves the pins unchanged.
- R5: The first underflow comes (reload+1)·div clock edges after the mode write that activates the group. Later underflows repeat every (reload+1)·div edges. The reload value is at address 6 or 7.
- R6: The clock select field, bits [1:0] at address 4 or 5, sets div as follows: 00 gives 2, 01 gives 16, 10 gives 64 and 11 gives 512.
- R7: Mode bit 3 inverts group 0's pulse output when it is 1. It has no effect on group 1.
- R8: When mode bit 4 is 1, group 1's active pulse outputs are forced to 0 while `pwm_gate` is low. When mode bit 4 is 0, `pwm_gate` is ignored.
- R9: Mode bit 5 enables group 0's waveform output and mode bit 6 enables group 1's. A group with its enable at 0 stays a parallel port whatever the select field says.
- R10: A write to the mode register takes effect only while bit 0 of the unlock register (address 0) is 1. Otherwise the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| pwm_gate | input | 1 | Modulation timer output that gates group 1 |
| pins0 | output | 4 | Group 0 pins |
| pins1 | output | 4 | Group 1 pins |

## Verification
A wrong timer count or prescaler phase shows up as a pin change that comes too early or too late. The bench measures the edge count from activation to the first pin update, and from one update to the next, so an error of one cycle is caught. A latch that takes data outside an underflow shows up on the pins one edge after the offending write. A broken lock or a wrong select decode shows up at once: a group that should hold its pattern follows the data writes instead, or the reverse.

// File: rtl/rtpo_pkg.sv
package rtpo_pkg;

  localparam int NGRP     = 2;
  localparam int ADDR_W   = 3;
  localparam int PS_W     = 9;

  localparam int A_UNLOCK = 0;
  localparam int A_MODE   = 1;
  localparam int A_DATA   = 2;
  localparam int A_CSEL   = 4;
  localparam int A_RELOAD = 6;

  typedef struct packed {
    logic       en1;
    logic       en0;
    logic       pwm1;
    logic       pol0;
    logic [2:0] sel;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  function automatic logic [PS_W-1:0] div_mask(input logic [1:0] cs);
    case (cs)
      2'b00:   return PS_W'(1);
      2'b01:   return PS_W'(15);
      2'b10:   return PS_W'(63);
      default: return PS_W'(511);
    endcase
  endfunction

  function automatic logic grp_active(input mode_t m, input int g);
    if (g == 0) return m.en0 && (m.sel == 3'b010 || m.sel == 3'b011);
    else        return m.en1 && (m.sel == 3'b001 || m.sel == 3'b011);
  endfunction

endpackage

// File: rtl/rtpo_regs.sv
module rtpo_regs
  import rtpo_pkg::*;
#(
  parameter int GRP_W  = 4,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [DATA_W-1:0]           wr_data,
  output mode_t                       mode,
  output logic [NGRP-1:0][GRP_W-1:0]  data,
  output logic [NGRP-1:0][1:0]        csel,
  output logic [NGRP-1:0][CNT_W-1:0]  reload
);

  logic unlock_q;
  logic mode_wr;

  assign mode_wr = wr_en && (wr_addr == ADDR_W'(A_MODE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlock_q <= 1'b0;
      mode     <= '0;
      data     <= '0;
      csel     <= '0;
      reload   <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(A_UNLOCK)) unlock_q <= wr_data[0];
      if (mode_wr && unlock_q) mode <= mode_t'(wr_data[MODE_W-1:0]);
      for (int g = 0; g < NGRP; g++) begin
        if (wr_addr == ADDR_W'(A_DATA + g))   data[g]   <= wr_data[GRP_W-1:0];
        if (wr_addr == ADDR_W'(A_CSEL + g))   csel[g]   <= wr_data[1:0];
        if (wr_addr == ADDR_W'(A_RELOAD + g)) reload[g] <= wr_data[CNT_W-1:0];
      end
    end
  end

  // R10
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && !unlock_q) |=> $stable(mode));

endmodule

// File: rtl/rtpo_timer.sv
module rtpo_timer
  import rtpo_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [1:0]       cs,
  input  logic [CNT_W-1:0] reload,
  output logic             uf
);

  logic [PS_W-1:0]  ps_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PS_W-1:0]  mask;
  logic             tick;

  assign mask = div_mask(cs);
  assign tick = run && ((ps_q & mask) == mask);
  assign uf   = tick && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps_q  <= '0;
      cnt_q <= '0;
    end else if (!run) begin
      ps_q  <= '0;
      cnt_q <= reload;
    end else begin
      ps_q <= ps_q + 1'b1;
      if (tick) cnt_q <= uf ? reload : cnt_q - 1'b1;
    end
  end

  // R5
  reload_after_uf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uf |=> (cnt_q == $past(reload)));

  // R6
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uf |=> !uf);

endmodule

// File: rtl/rtpo_group.sv
module rtpo_group #(
  parameter int GRP_W   = 4,
  parameter bit HAS_POL = 1'b0,
  parameter bit HAS_PWM = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             uf,
  input  logic [GRP_W-1:0] data,
  input  logic             pol,
  input  logic             pwm_en,
  input  logic             gate,
  output logic [GRP_W-1:0] pins
);

  logic [GRP_W-1:0] latch_q;
  logic [GRP_W-1:0] shaped;
  logic [GRP_W-1:0] gated;
  logic             inv_eff;
  logic             mute;

  assign inv_eff = HAS_POL ? pol : 1'b0;
  assign mute    = HAS_PWM ? (pwm_en && !gate) : 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n)               latch_q <= '0;
    else if (!active || uf)   latch_q <= data;
  end

  assign shaped = inv_eff ? ~latch_q : latch_q;
  assign gated  = mute ? '0 : shaped;
  assign pins   = active ? gated : data;

  // R4
  hold_between_uf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !uf) |=> (latch_q == $past(latch_q)));

endmodule

// File: rtl/rtpo_top.sv
module rtpo_top
  import rtpo_pkg::*;
#(
  parameter int GRP_W  = 4,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pwm_gate,
  output logic [GRP_W-1:0]  pins0,
  output logic [GRP_W-1:0]  pins1
);

  mode_t                      mode;
  logic [NGRP-1:0][GRP_W-1:0] data;
  logic [NGRP-1:0][1:0]       csel;
  logic [NGRP-1:0][CNT_W-1:0] reload;
  logic [NGRP-1:0]            act;
  logic [NGRP-1:0]            uf;
  logic [NGRP-1:0]            pol_v;
  logic [NGRP-1:0]            pwm_v;
  logic [NGRP-1:0][GRP_W-1:0] pins;

  rtpo_regs #(.GRP_W(GRP_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .mode    (mode),
    .data    (data),
    .csel    (csel),
    .reload  (reload)
  );

  assign pol_v = {1'b0, mode.pol0};
  assign pwm_v = {mode.pwm1, 1'b0};

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign act[g] = grp_active(mode, g);

    rtpo_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (act[g]),
      .cs     (csel[g]),
      .reload (reload[g]),
      .uf     (uf[g])
    );

    rtpo_group #(.GRP_W(GRP_W), .HAS_POL(g == 0), .HAS_PWM(g == 1)) u_grp (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (act[g]),
      .uf     (uf[g]),
      .data   (data[g]),
      .pol    (pol_v[g]),
      .pwm_en (pwm_v[g]),
      .gate   (pwm_gate),
      .pins   (pins[g])
    );
  end

  assign pins0 = pins[0];
  assign pins1 = pins[1];

  // R3
  both_need_sel3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act[0] && act[1]) |-> (mode.sel == 3'b011));

  // R9
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode.en0 || !mode.en1) |-> !(act[0] && act[1]));

endmodule

// File: tb/tb_rtpo_top.sv
module tb_rtpo_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pwm_gate = 1'b0;
  logic [3:0] pins0;
  logic [3:0] pins1;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  rtpo_top dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_gate(pwm_gate), .pins0(pins0), .pins1(pins1)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  function automatic logic [3:0] pins_of(input int g);
    return (g == 0) ? pins0 : pins1;
  endfunction

  function automatic int div_of(input int cs);
    case (cs)
      0: return 2;
      1: return 16;
      2: return 64;
      default: return 512;
    endcase
  endfunction

  task automatic set_slow();
    wr(4, 3); wr(5, 3); wr(6, 255); wr(7, 255);
  endtask

  task automatic t_reset();
    chk(pins0 == 4'h0, "R1 pins0", pins0, 0);
    chk(pins1 == 4'h0, "R1 pins1", pins1, 0);
  endtask

  task automatic t_lock_parallel();
    wr(1, 8'h6B);
    wr(2, 5);
    chk(pins0 == 4'h5, "R10 locked mode, R2 group0 follows", pins0, 5);
    wr(3, 8'hFA);
    chk(pins1 == 4'hA, "R2 group1 follows low nibble", pins1, 10);
    wr(0, 1);
    wr(1, 8'h22);
    wr(2, 6);
    chk(pins0 == 4'h5, "R10 unlocked mode takes effect", pins0, 5);
    wr(1, 0);
    chk(pins0 == 4'h6, "R2 back to parallel", pins0, 6);
  endtask

  task automatic t_timing(input int g, input int cs, input int rl);
    int per;
    int n;
    logic [3:0] old;
    per = (rl + 1) * div_of(cs);
    wr(4 + g, cs); wr(6 + g, rl); wr(2 + g, 0);
    wr(1, (g == 0) ? 8'h22 : 8'h41);
    old = pins_of(g);
    n = 0;
    wr(2 + g, 9); n++;
    chk(pins_of(g) == old, "R4 write does not reach pins", pins_of(g), old);
    while (n < per + 20) begin
      @(posedge clk); n++; #1;
      if (pins_of(g) != old) break;
    end
    chk(n == per, "R5 R6 first underflow edge", n, per);
    chk(pins_of(g) == 4'h9, "R4 pins take data at underflow", pins_of(g), 9);
    old = pins_of(g);
    n = 0;
    wr(2 + g, 6); n++;
    while (n < per + 20) begin
      @(posedge clk); n++; #1;
      if (pins_of(g) != old) break;
    end
    chk(n == per, "R5 R6 repeat period", n, per);
    chk(pins_of(g) == 4'h6, "R4 second pattern", pins_of(g), 6);
    wr(1, 0);
  endtask

  task automatic t_select();
    set_slow();
    wr(2, 3); wr(3, 12);
    wr(1, 8'h61);
    wr(2, 5);
    chk(pins0 == 4'h5, "R3 sel001 group0 parallel", pins0, 5);
    wr(3, 7);
    chk(pins1 == 4'hC, "R3 sel001 group1 holds", pins1, 12);
    wr(1, 8'h62);
    chk(pins1 == 4'h7, "R3 sel010 group1 parallel", pins1, 7);
    wr(2, 2);
    chk(pins0 == 4'h5, "R3 sel010 group0 holds", pins0, 5);
    wr(1, 8'h60);
    chk(pins0 == 4'h2, "R3 sel000 parallel", pins0, 2);
    wr(1, 8'h67);
    wr(3, 1);
    chk(pins1 == 4'h1, "R3 sel111 parallel", pins1, 1);
    wr(1, 0);
  endtask

  task automatic t_enable();
    set_slow();
    wr(2, 4); wr(3, 4);
    wr(1, 8'h23);
    wr(3, 14);
    chk(pins1 == 4'hE, "R9 group1 disabled stays parallel", pins1, 14);
    wr(2, 8);
    chk(pins0 == 4'h4, "R9 group0 enabled holds", pins0, 4);
    wr(1, 8'h43);
    wr(2, 1);
    chk(pins0 == 4'h1, "R9 group0 disabled stays parallel", pins0, 1);
    wr(1, 0);
  endtask

  task automatic t_polarity();
    set_slow();
    wr(2, 3); wr(3, 11);
    wr(1, 8'h2A);
    chk(pins0 == 4'hC, "R7 group0 inverted", pins0, 12);
    wr(1, 8'h22);
    chk(pins0 == 4'h3, "R7 group0 positive", pins0, 3);
    wr(1, 8'h49);
    chk(pins1 == 4'hB, "R7 no effect on group1", pins1, 11);
    wr(1, 0);
  endtask

  task automatic t_pwm();
    set_slow();
    wr(3, 11);
    pwm_gate = 1'b0;
    wr(1, 8'h51);
    chk(pins1 == 4'h0, "R8 gated low", pins1, 0);
    @(negedge clk); pwm_gate = 1'b1; #1;
    chk(pins1 == 4'hB, "R8 gate high passes", pins1, 11);
    @(negedge clk); pwm_gate = 1'b0;
    wr(1, 8'h41);
    chk(pins1 == 4'hB, "R8 gate ignored when off", pins1, 11);
    wr(1, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_lock_parallel();
    t_timing(1, 0, 3);
    t_timing(0, 1, 2);
    t_timing(1, 2, 1);
    t_timing(0, 3, 0);
    t_select();
    t_enable();
    t_polarity();
    t_pwm();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2ms;
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule